// File: doc/BRIEF.md
# CPU Exception Entry and Return Controller

This block handles trap entry and return for a simple 32-bit in-order core. The pipeline raises one-cycle cause strobes: breakpoint, data bus error, divide by zero and system call. Alongside them it supplies the address of the faulting instruction. A data bus error covers both unmapped and misaligned data accesses. In the cycle after a strobe the block issues three things:

- a program-counter redirect to the handler vector;
- a register-file write that saves the faulting address;
- an update of its three-bit interrupt-enable stack.

Breakpoints keep their own saved enable bit and their own register slot, and they vector through a separate debug base. This lets a debugger trap inside an ordinary exception handler.

The block holds four control registers: interrupt enable, interrupt pending, the exception base and the debug base. It accepts writes to them through a simple write port. When the core executes a register-indirect branch, it reports the branch to the block. A branch through register 30 or register 31 restores the matching saved enable bit.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After synchronous reset, the interrupt-enable value, the pending value, the exception base and the debug base are all zero, and `redirect_valid` and `rf_we` are low.
- R2: When several cause strobes are high in one cycle, only one trap is taken. The priority is breakpoint, then data bus error, then divide by zero, then system call.
- R3: A data bus error, divide by zero or system call writes `fault_pc` into register 30. It redirects to the exception base plus 32 times the trap code, with codes data bus error = 4, divide by zero = 5 and system call = 7.
- R4: A breakpoint writes `fault_pc` into register 31 and redirects to the debug base plus 32 (trap code 1).
- R5: On a non-breakpoint trap, the new interrupt-enable value is the old bit 0 moved to bit 1, with bits 0 and 2 cleared.
- R6: On a breakpoint trap, the new interrupt-enable value is the old bit 0 moved to bit 2, with bits 0 and 1 cleared.
- R7: A reported branch through register 30 sets interrupt enable to {0,0,old bit 1}. A branch through register 31 sets it to {0,0,old bit 2}. A branch through any other register leaves it unchanged.
- R8: A write to the pending register (`csr_sel` = 1) clears every bit written as 1 and keeps every bit written as 0. Bits raised on `irq_set` in the same cycle are set regardless of the clear.
- R9: Writes to interrupt enable (`csr_sel` = 0, bits 2:0), the exception base (`csr_sel` = 2) and the debug base (`csr_sel` = 3) replace the value. The low 8 bits of both bases always read as zero.
- R10: The redirect, the register write and the new enable value appear one clock after the strobe, and the redirect lasts one cycle. A trap's enable update takes precedence over a branch report or a CSR write to interrupt enable made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_brk | input | 1 | Breakpoint strobe |
| cause_dbe | input | 1 | Data bus error strobe (unmapped or misaligned access) |
| cause_div0 | input | 1 | Divide-by-zero strobe |
| cause_scall | input | 1 | System call strobe |
| fault_pc | input | 32 | Address of the faulting instruction |
| br_valid | input | 1 | Register-indirect branch executed |
| br_reg | input | 5 | Index of the branch target register |
| csr_we | input | 1 | Control register write enable |
| csr_sel | input | 2 | Register select: 0 enable, 1 pending, 2 exception base, 3 debug base |
| csr_wdata | input | 32 | Control register write data |
| irq_set | input | 32 | Pending bits to raise this cycle |
| redirect_valid | output | 1 | Program-counter redirect |
| redirect_pc | output | 32 | Handler vector address |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index (30 or 31) |
| rf_wdata | output | 32 | Saved faulting address |
| ie_out | output | 3 | Interrupt-enable stack |
| ip_out | output | 32 | Interrupt-pending register |
| eba_out | output | 32 | Exception base |
| deba_out | output | 32 | Debug base |

## Verification
The assertions check the following on every cycle:

- the one-cycle latency from a strobe to the redirect, and the absence of a redirect without a strobe;
- the 32-byte vector alignment and the aligned bases;
- the breakpoint's choice of register 31 and its enable-stack push;
- the restore on a branch through register 30;
- the write-one-to-clear rule on the pending register.

Only the bench's scenarios can show the following:

- the exact vector address for each trap code;
- the priority order under simultaneous strobes;
- the unchanged enable on a branch through an ordinary register;
- a set on `irq_set` overriding a clear in the same cycle;
- a trap's precedence over a same-cycle enable write.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int ID_W = 3;

    typedef enum logic [ID_W-1:0] {
        EXC_RESET   = 3'd0,
        EXC_BREAK   = 3'd1,
        EXC_IBUS    = 3'd2,
        EXC_WATCH   = 3'd3,
        EXC_DBUS    = 3'd4,
        EXC_DIV0    = 3'd5,
        EXC_IRQ     = 3'd6,
        EXC_SCALL   = 3'd7
    } exc_id_e;

    typedef enum logic [1:0] {
        CSR_IE   = 2'd0,
        CSR_IP   = 2'd1,
        CSR_EBA  = 2'd2,
        CSR_DEBA = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic    valid;
        logic    is_brk;
        exc_id_e id;
    } exc_req_t;

    // Enable stack after entering a trap: old live bit is parked in its slot.
    function automatic logic [2:0] ie_on_entry(input logic [2:0] ie, input logic is_brk);
        return is_brk ? {ie[0], 2'b00} : {1'b0, ie[0], 1'b0};
    endfunction

endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
    import exc_pkg::*;
(
    input  logic     brk,
    input  logic     dbe,
    input  logic     div0,
    input  logic     scall,
    output exc_req_t req
);
    always_comb begin
        req = '{valid: 1'b0, is_brk: 1'b0, id: EXC_RESET};
        if (brk) begin
            req = '{valid: 1'b1, is_brk: 1'b1, id: EXC_BREAK};
        end else if (dbe) begin
            req = '{valid: 1'b1, is_brk: 1'b0, id: EXC_DBUS};
        end else if (div0) begin
            req = '{valid: 1'b1, is_brk: 1'b0, id: EXC_DIV0};
        end else if (scall) begin
            req = '{valid: 1'b1, is_brk: 1'b0, id: EXC_SCALL};
        end
    end
endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
    import exc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int IRQ_W     = 32,
    parameter int BASE_LSB  = 8,
    parameter int RIDX_W    = 5,
    parameter int EA_IDX    = 30,
    parameter int BA_IDX    = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  exc_req_t          req,
    input  logic              br_valid,
    input  logic [RIDX_W-1:0] br_reg,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [IRQ_W-1:0]  irq_set,
    output logic [2:0]        ie,
    output logic [IRQ_W-1:0]  ip,
    output logic [XLEN-1:0]   eba,
    output logic [XLEN-1:0]   deba
);
    localparam int BASE_HI_W = XLEN - BASE_LSB;

    logic [BASE_HI_W-1:0] eba_hi, deba_hi;
    logic [2:0]           ie_nxt;
    logic [IRQ_W-1:0]     ip_clr;
    logic                 ret_ea, ret_ba;

    assign ret_ea = br_valid && (br_reg == RIDX_W'(EA_IDX));
    assign ret_ba = br_valid && (br_reg == RIDX_W'(BA_IDX));

    always_comb begin
        ie_nxt = ie;
        if (req.valid) begin
            ie_nxt = ie_on_entry(ie, req.is_brk);
        end else if (ret_ea) begin
            ie_nxt = {2'b00, ie[1]};
        end else if (ret_ba) begin
            ie_nxt = {2'b00, ie[2]};
        end else if (csr_we && csr_sel == CSR_IE) begin
            ie_nxt = csr_wdata[2:0];
        end
    end

    assign ip_clr = (csr_we && csr_sel == CSR_IP) ? csr_wdata[IRQ_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie      <= '0;
            ip      <= '0;
            eba_hi  <= '0;
            deba_hi <= '0;
        end else begin
            ie <= ie_nxt;
            ip <= (ip & ~ip_clr) | irq_set;
            if (csr_we && csr_sel == CSR_EBA)  eba_hi  <= csr_wdata[XLEN-1:BASE_LSB];
            if (csr_we && csr_sel == CSR_DEBA) deba_hi <= csr_wdata[XLEN-1:BASE_LSB];
        end
    end

    assign eba  = {eba_hi,  {BASE_LSB{1'b0}}};
    assign deba = {deba_hi, {BASE_LSB{1'b0}}};
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int RIDX_W     = 5,
    parameter int VEC_SHIFT  = 5,
    parameter int EA_IDX     = 30,
    parameter int BA_IDX     = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  exc_req_t          req,
    input  logic [XLEN-1:0]   fault_pc,
    input  logic [XLEN-1:0]   eba,
    input  logic [XLEN-1:0]   deba,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata
);
    logic [XLEN-1:0] base, offset;

    assign base   = req.is_brk ? deba : eba;
    assign offset = XLEN'(req.id) << VEC_SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            rf_we          <= 1'b0;
            redirect_pc    <= '0;
            rf_waddr       <= '0;
            rf_wdata       <= '0;
        end else begin
            redirect_valid <= req.valid;
            rf_we          <= req.valid;
            if (req.valid) begin
                redirect_pc <= base + offset;
                rf_waddr    <= req.is_brk ? RIDX_W'(BA_IDX) : RIDX_W'(EA_IDX);
                rf_wdata    <= fault_pc;
            end
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int IRQ_W     = 32,
    parameter int BASE_LSB  = 8,
    parameter int VEC_SHIFT = 5,
    parameter int RIDX_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cause_brk,
    input  logic              cause_dbe,
    input  logic              cause_div0,
    input  logic              cause_scall,
    input  logic [XLEN-1:0]   fault_pc,
    input  logic              br_valid,
    input  logic [RIDX_W-1:0] br_reg,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [IRQ_W-1:0]  irq_set,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic [2:0]        ie_out,
    output logic [IRQ_W-1:0]  ip_out,
    output logic [XLEN-1:0]   eba_out,
    output logic [XLEN-1:0]   deba_out
);
    localparam int EA_IDX = (1 << RIDX_W) - 2;
    localparam int BA_IDX = (1 << RIDX_W) - 1;

    exc_req_t req;

    exc_cause_arb u_arb (
        .brk   (cause_brk),
        .dbe   (cause_dbe),
        .div0  (cause_div0),
        .scall (cause_scall),
        .req   (req)
    );

    exc_csr_bank #(
        .XLEN(XLEN), .IRQ_W(IRQ_W), .BASE_LSB(BASE_LSB),
        .RIDX_W(RIDX_W), .EA_IDX(EA_IDX), .BA_IDX(BA_IDX)
    ) u_csr (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .br_valid  (br_valid),
        .br_reg    (br_reg),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .irq_set   (irq_set),
        .ie        (ie_out),
        .ip        (ip_out),
        .eba       (eba_out),
        .deba      (deba_out)
    );

    exc_vector_gen #(
        .XLEN(XLEN), .RIDX_W(RIDX_W), .VEC_SHIFT(VEC_SHIFT),
        .EA_IDX(EA_IDX), .BA_IDX(BA_IDX)
    ) u_vec (
        .clk            (clk),
        .rst            (rst),
        .req            (req),
        .fault_pc       (fault_pc),
        .eba            (eba_out),
        .deba           (deba_out),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .rf_we          (rf_we),
        .rf_waddr       (rf_waddr),
        .rf_wdata       (rf_wdata)
    );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XLEN      = 32,
    parameter int IRQ_W     = 32,
    parameter int BASE_LSB  = 8,
    parameter int VEC_SHIFT = 5,
    parameter int RIDX_W    = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cause_brk,
    input logic              cause_dbe,
    input logic              cause_div0,
    input logic              cause_scall,
    input logic              br_valid,
    input logic [RIDX_W-1:0] br_reg,
    input logic              csr_we,
    input logic [1:0]        csr_sel,
    input logic [XLEN-1:0]   csr_wdata,
    input logic [IRQ_W-1:0]  irq_set,
    input logic              redirect_valid,
    input logic [XLEN-1:0]   redirect_pc,
    input logic [RIDX_W-1:0] rf_waddr,
    input logic [2:0]        ie_out,
    input logic [IRQ_W-1:0]  ip_out,
    input logic [XLEN-1:0]   eba_out,
    input logic [XLEN-1:0]   deba_out
);
    logic any_cause;
    assign any_cause = cause_brk | cause_dbe | cause_div0 | cause_scall;

    assert_redirect_after_cause_R10: assert property (@(posedge clk) disable iff (rst)
        any_cause |=> redirect_valid);

    assert_no_spurious_redirect_R10: assert property (@(posedge clk) disable iff (rst)
        !any_cause |=> !redirect_valid);

    assert_vector_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (redirect_pc[VEC_SHIFT-1:0] == '0));

    assert_bases_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        (eba_out[BASE_LSB-1:0] == '0) && (deba_out[BASE_LSB-1:0] == '0));

    assert_brk_slot_R4: assert property (@(posedge clk) disable iff (rst)
        cause_brk |=> (rf_waddr == {RIDX_W{1'b1}}));

    assert_brk_ie_push_R6: assert property (@(posedge clk) disable iff (rst)
        cause_brk |=> (ie_out == {$past(ie_out[0]), 2'b00}));

    assert_ret_ea_restore_R7: assert property (@(posedge clk) disable iff (rst)
        (!any_cause && br_valid && br_reg == RIDX_W'((1 << RIDX_W) - 2))
        |=> (ie_out == {2'b00, $past(ie_out[1])}));

    assert_ip_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_sel == 2'd1 && irq_set == '0)
        |=> ((ip_out & $past(csr_wdata[IRQ_W-1:0])) == '0));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN(XLEN), .IRQ_W(IRQ_W), .BASE_LSB(BASE_LSB),
    .VEC_SHIFT(VEC_SHIFT), .RIDX_W(RIDX_W)
) u_chk (
    .clk(clk), .rst(rst),
    .cause_brk(cause_brk), .cause_dbe(cause_dbe),
    .cause_div0(cause_div0), .cause_scall(cause_scall),
    .br_valid(br_valid), .br_reg(br_reg),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .irq_set(irq_set),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .rf_waddr(rf_waddr), .ie_out(ie_out), .ip_out(ip_out),
    .eba_out(eba_out), .deba_out(deba_out)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cause_brk, cause_dbe, cause_div0, cause_scall;
    logic [31:0] fault_pc;
    logic        br_valid;
    logic [4:0]  br_reg;
    logic        csr_we;
    logic [1:0]  csr_sel;
    logic [31:0] csr_wdata;
    logic [31:0] irq_set;
    logic        redirect_valid, rf_we;
    logic [31:0] redirect_pc, rf_wdata, ip_out, eba_out, deba_out;
    logic [4:0]  rf_waddr;
    logic [2:0]  ie_out;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] EBA  = 32'h0001_2300;
    localparam logic [31:0] DEBA = 32'h00AB_CD00;

    always #2.5 clk = ~clk;

    exc_entry_ctrl uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cause_brk = 0; cause_dbe = 0; cause_div0 = 0; cause_scall = 0;
        fault_pc = '0; br_valid = 0; br_reg = '0;
        csr_we = 0; csr_sel = '0; csr_wdata = '0; irq_set = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic csr_write(input logic [1:0] sel, input logic [31:0] d);
        csr_we = 1; csr_sel = sel; csr_wdata = d;
        tick();
    endtask

    task automatic ret_via(input logic [4:0] r);
        br_valid = 1; br_reg = r;
        tick();
    endtask

    task automatic expect_entry(input string req, input logic [31:0] pc,
                                input logic [4:0] slot, input logic [31:0] fpc,
                                input logic [2:0] ie);
        chk({req, " redirect_valid"}, 32'(redirect_valid), 32'd1);
        chk({req, " rf_we"}, 32'(rf_we), 32'd1);
        chk({req, " redirect_pc"}, redirect_pc, pc);
        chk({req, " rf_waddr"}, 32'(rf_waddr), 32'(slot));
        chk({req, " rf_wdata"}, rf_wdata, fpc);
        chk({req, " ie"}, 32'(ie_out), 32'(ie));
    endtask

    task automatic t_reset();
        chk("R1 ie", 32'(ie_out), 0);
        chk("R1 ip", ip_out, 0);
        chk("R1 eba", eba_out, 0);
        chk("R1 deba", deba_out, 0);
        chk("R1 redirect", 32'(redirect_valid), 0);
        chk("R1 rf_we", 32'(rf_we), 0);
    endtask

    task automatic t_csr_setup();
        csr_write(2'd0, 32'h1);
        chk("R9 ie write", 32'(ie_out), 1);
        csr_write(2'd2, EBA | 32'hFF);
        chk("R9 eba low bits zero", eba_out, EBA);
        csr_write(2'd3, DEBA | 32'h55);
        chk("R9 deba low bits zero", deba_out, DEBA);
    endtask

    task automatic t_div0_and_return();
        cause_div0 = 1; fault_pc = 32'h0000_1000;
        tick();
        expect_entry("R3 R5 div0", EBA + 32'd160, 5'd30, 32'h1000, 3'b010);
        tick();
        chk("R10 redirect one cycle", 32'(redirect_valid), 0);
        ret_via(5'd30);
        chk("R7 return r30", 32'(ie_out), 3'b001);
    endtask

    task automatic t_break_and_returns();
        cause_brk = 1; fault_pc = 32'h0000_2004;
        tick();
        expect_entry("R4 R6 brk", DEBA + 32'd32, 5'd31, 32'h2004, 3'b100);
        ret_via(5'd5);
        chk("R7 return other reg", 32'(ie_out), 3'b100);
        ret_via(5'd31);
        chk("R7 return r31", 32'(ie_out), 3'b001);
    endtask

    task automatic t_priority();
        cause_brk = 1; cause_dbe = 1; cause_div0 = 1; cause_scall = 1; fault_pc = 32'h3000;
        tick();
        expect_entry("R2 all four -> brk", DEBA + 32'd32, 5'd31, 32'h3000, 3'b100);
        ret_via(5'd31);
        cause_dbe = 1; cause_div0 = 1; cause_scall = 1; fault_pc = 32'h3100;
        tick();
        expect_entry("R2 dbe wins", EBA + 32'd128, 5'd30, 32'h3100, 3'b010);
        ret_via(5'd30);
        cause_div0 = 1; cause_scall = 1; fault_pc = 32'h3200;
        tick();
        expect_entry("R2 div0 over scall", EBA + 32'd160, 5'd30, 32'h3200, 3'b010);
        ret_via(5'd30);
        cause_scall = 1; fault_pc = 32'h3300;
        tick();
        expect_entry("R3 scall", EBA + 32'd224, 5'd30, 32'h3300, 3'b010);
    endtask

    task automatic t_disabled_entry();
        csr_write(2'd0, 32'h0);
        cause_scall = 1; fault_pc = 32'h4000;
        tick();
        chk("R5 entry with ie0 clear", 32'(ie_out), 3'b000);
    endtask

    task automatic t_same_cycle();
        csr_write(2'd0, 32'h1);
        cause_div0 = 1; fault_pc = 32'h5000;
        csr_we = 1; csr_sel = 2'd0; csr_wdata = 32'h7;
        tick();
        chk("R10 entry beats ie write", 32'(ie_out), 3'b010);
        cause_brk = 1; fault_pc = 32'h5004; br_valid = 1; br_reg = 5'd30;
        tick();
        chk("R10 entry beats return", 32'(ie_out), 3'b000);
    endtask

    task automatic t_pending();
        irq_set = 32'h0000_F0F0;
        tick();
        chk("R8 set", ip_out, 32'h0000_F0F0);
        csr_write(2'd1, 32'h0000_00F0);
        chk("R8 w1c", ip_out, 32'h0000_F000);
        csr_write(2'd1, 32'h0);
        chk("R8 zero write no effect", ip_out, 32'h0000_F000);
        irq_set = 32'h0000_000F;
        csr_we = 1; csr_sel = 2'd1; csr_wdata = 32'h0000_000F;
        tick();
        chk("R8 set wins over clear", ip_out, 32'h0000_F00F);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        t_reset();
        t_csr_setup();
        t_div0_and_return();
        t_break_and_returns();
        t_priority();
        t_disabled_entry();
        t_same_cycle();
        t_pending();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule